// File: doc/BRIEF.md
# Per-Core GPIO Interrupt Router

This block sits beside a GPIO controller and decides which processor cores are told about each pending GPIO line. Every core owns one 32-bit routing mask, one bit per line. A set bit lets that line's pending status raise the core's interrupt, and a clear bit keeps it away from that core. The block drives one interrupt output per core. The output is high when at least one pending line is also enabled in that core's mask.

The masks live in a small word-addressed window: the mask for core n is at byte offset 4·n. Software reads a mask, changes one bit and writes the word back, so every mask can be read back in full. The bit layout of a mask word on the bus is the same port packing that the controller uses for its one-bit-per-line registers. A parameter selects normal or reversed port order. The core count (1 to 4) and the number of implemented lines (1 to 32) are parameters. Edge detection and the clearing of pending status remain in the GPIO controller. This block only reads the status vector.

Top module: `gpio_cpu_irq_route`

## Requirements
- R1: While reset is active and on the first cycle after it, `irq_o` and `bus_rdata` are 0. Every mask resets to ones on all implemented lines and zeros above them, so every core first receives every implemented line.
- R2: The mask for core n is at byte offset 4·n of the window. An access whose offset has either of its two low bits set is treated as out of range.
- R3: A write (`bus_sel`=1, `bus_wr`=1) to an in-range offset replaces that core's whole mask with `bus_wdata`, translated by the port packing. Bits for lines that are not implemented are stored as 0. The other masks do not change.
- R4: A read (`bus_sel`=1, `bus_wr`=0) places that core's mask, in bus packing, on `bus_rdata` one clock after the access.
- R5: Port packing: with `PORTS_REVERSED`=0, line 8p+k (port p, bit k) is bus bit 8·(3−p)+k. With `PORTS_REVERSED`=1, line n is bus bit n. The same mapping applies to writes and to reads.
- R6: `irq_o[n]` is 1 exactly one clock after a cycle in which `pend_i & mask[n]` has any implemented bit set. Otherwise it is 0.
- R7: A read at an out-of-range offset (misaligned, or core index ≥ `NUM_CORES`) returns 0. A write there changes no mask.
- R8: Status bits and written bits for lines at or above `NUM_LINES` have no effect on `irq_o` and read back as 0.
- R9: `bus_rdata` holds its last value through cycles that carry no read, writes included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pend_i | input | 32 | Pending status per line from the GPIO controller, bit n = line n |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the routing window |
| bus_wdata | input | 32 | Write word in bus packing |
| bus_rdata | output | 32 | Read word, valid the cycle after a read |
| irq_o | output | NUM_CORES | Interrupt request per core, registered |

## Verification
The bound assertions check the following on every cycle: each core's interrupt follows the masked status of the cycle before, out-of-range writes leave all masks unchanged, out-of-range reads return zero, unimplemented lines never appear in read data, and read data holds between reads. Some behaviour can only be shown by the bench scenarios, because it depends on bus encodings that software chooses. These are the reset-time routing to all cores, the difference between the two port packings for the same written word, and per-line affinity, where one pending line reaches some cores and not others. The bench runs both packings at once and uses a narrower line count on one instance.

// File: rtl/gcir_pkg.sv
package gcir_pkg;

  typedef logic [31:0] line_vec_t;

  // Convert between logical line order and the bus image.
  // Normal order puts port 0 in the top byte; reversed order is identity.
  // The mapping is its own inverse.
  function automatic line_vec_t pack_order(input line_vec_t v, input bit rev);
    return rev ? v : {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  // Ones for each implemented line, zeros above.
  function automatic line_vec_t line_fill(input int n);
    line_vec_t r;
    for (int i = 0; i < 32; i++) r[i] = (i < n);
    return r;
  endfunction

endpackage

// File: rtl/gcir_mask_bank.sv
module gcir_mask_bank
  import gcir_pkg::*;
#(
  parameter int        NUM_CORES = 3,
  parameter int        IDX_W     = 2,
  parameter line_vec_t IMPL      = '1,
  parameter bit        REV       = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic                       in_range,
  input  logic [IDX_W-1:0]           idx,
  input  line_vec_t                  wr_lines,
  output line_vec_t [NUM_CORES-1:0]  mask_q,
  output logic [31:0]                rdata
);

  line_vec_t rd_sel;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic hit;
    assign hit = wr_en && (idx == IDX_W'(c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mask_q[c] <= IMPL;
      else if (hit) mask_q[c] <= wr_lines & IMPL;
    end
  end

  always_comb begin
    rd_sel = '0;
    for (int c = 0; c < NUM_CORES; c++)
      if (in_range && idx == IDX_W'(c)) rd_sel = mask_q[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= pack_order(rd_sel, REV);
  end

endmodule

// File: rtl/gcir_irq_reduce.sv
module gcir_irq_reduce
  import gcir_pkg::*;
#(
  parameter int NUM_CORES = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  line_vec_t                 pend,
  input  line_vec_t [NUM_CORES-1:0] mask_q,
  output logic [NUM_CORES-1:0]      irq_q
);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_or
    logic any_hit;
    assign any_hit = |(pend & mask_q[c]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q[c] <= 1'b0;
      else        irq_q[c] <= any_hit;
    end
  end

endmodule

// File: rtl/gpio_cpu_irq_route.sv
module gpio_cpu_irq_route
  import gcir_pkg::*;
#(
  parameter int NUM_CORES      = 3,
  parameter int NUM_LINES      = 32,
  parameter bit PORTS_REVERSED = 1'b0,
  parameter int ADDR_W         = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [31:0]           pend_i,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic [NUM_CORES-1:0]  irq_o
);

  localparam int        IDX_W = ADDR_W - 2;
  localparam line_vec_t IMPL  = line_fill(NUM_LINES);

  // Named events for the checker
  logic                      acc_aligned;
  logic [IDX_W-1:0]          acc_idx;
  logic                      acc_in_range;
  logic                      acc_wr;
  logic                      acc_rd;
  line_vec_t                 wr_lines;
  line_vec_t                 pend_eff;
  line_vec_t [NUM_CORES-1:0] mask_q;

  assign acc_aligned  = (bus_addr[1:0] == 2'b00);
  assign acc_idx      = bus_addr[ADDR_W-1:2];
  assign acc_in_range = acc_aligned && (int'(acc_idx) < NUM_CORES);
  assign acc_wr       = bus_sel && bus_wr && acc_in_range;
  assign acc_rd       = bus_sel && !bus_wr;
  assign wr_lines     = pack_order(bus_wdata, PORTS_REVERSED);
  assign pend_eff     = pend_i & IMPL;

  gcir_mask_bank #(
    .NUM_CORES (NUM_CORES),
    .IDX_W     (IDX_W),
    .IMPL      (IMPL),
    .REV       (PORTS_REVERSED)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (acc_wr),
    .rd_en    (acc_rd),
    .in_range (acc_in_range),
    .idx      (acc_idx),
    .wr_lines (wr_lines),
    .mask_q   (mask_q),
    .rdata    (bus_rdata)
  );

  gcir_irq_reduce #(
    .NUM_CORES (NUM_CORES)
  ) u_reduce (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend   (pend_eff),
    .mask_q (mask_q),
    .irq_q  (irq_o)
  );

endmodule

// File: rtl/gpio_cpu_irq_route_chk.sv
module gpio_cpu_irq_route_chk
  import gcir_pkg::*;
#(
  parameter int NUM_CORES      = 3,
  parameter int NUM_LINES      = 32,
  parameter bit PORTS_REVERSED = 1'b0
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      acc_rd,
  input logic                      acc_wr,
  input logic                      acc_in_range,
  input logic                      bus_sel,
  input logic                      bus_wr,
  input line_vec_t                 pend_eff,
  input line_vec_t [NUM_CORES-1:0] mask_q,
  input logic [31:0]               bus_rdata,
  input logic [NUM_CORES-1:0]      irq_o
);

  localparam line_vec_t IMPL = line_fill(NUM_LINES);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core_chk
    // R6
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pend_eff & mask_q[c])) |=> irq_o[c]);
    // R6
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(pend_eff & mask_q[c])) |=> !irq_o[c]);
  end

  // R7
  oor_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !acc_in_range) |=> $stable(mask_q));

  // R7
  oor_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && !acc_in_range) |=> (bus_rdata == 32'd0));

  // R8
  high_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> ((pack_order(bus_rdata, PORTS_REVERSED) & ~IMPL) == 32'd0));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |=> $stable(bus_rdata));

  // R3
  no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> $stable(mask_q));

endmodule

bind gpio_cpu_irq_route gpio_cpu_irq_route_chk #(
  .NUM_CORES      (NUM_CORES),
  .NUM_LINES      (NUM_LINES),
  .PORTS_REVERSED (PORTS_REVERSED)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_rd       (acc_rd),
  .acc_wr       (acc_wr),
  .acc_in_range (acc_in_range),
  .bus_sel      (bus_sel),
  .bus_wr       (bus_wr),
  .pend_eff     (pend_eff),
  .mask_q       (mask_q),
  .bus_rdata    (bus_rdata),
  .irq_o        (irq_o)
);

// File: tb/gpio_cpu_irq_route_test.sv
module gpio_cpu_irq_route_test;

  localparam int CLK_PERIOD = 10;
  localparam int NC_A = 3, NL_A = 32;
  localparam int NC_B = 2, NL_B = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pend_i = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_a, rd_b;
  logic [NC_A-1:0] irq_a;
  logic [NC_B-1:0] irq_b;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] m_a [4];
  logic [31:0] m_b [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_cpu_irq_route #(.NUM_CORES(NC_A), .NUM_LINES(NL_A), .PORTS_REVERSED(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_a), .irq_o(irq_a));

  gpio_cpu_irq_route #(.NUM_CORES(NC_B), .NUM_LINES(NL_B), .PORTS_REVERSED(1'b1)) uut_rev (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_b), .irq_o(irq_b));

  function automatic logic [31:0] impl_of(input int n);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = 1'b1;
    return r;
  endfunction

  // Bus bit that holds line i.
  function automatic int bus_pos(input int i, input bit rev);
    return rev ? i : (3 - i / 8) * 8 + (i % 8);
  endfunction

  function automatic logic [31:0] to_bus(input logic [31:0] l, input bit rev);
    logic [31:0] o = '0;
    for (int i = 0; i < 32; i++) o[bus_pos(i, rev)] = l[i];
    return o;
  endfunction

  function automatic logic [31:0] from_bus(input logic [31:0] b, input bit rev);
    logic [31:0] l = '0;
    for (int i = 0; i < 32; i++) l[i] = b[bus_pos(i, rev)];
    return l;
  endfunction

  function automatic bit in_win(input logic [3:0] a, input int nc);
    return (a[1:0] == 2'b00) && (int'(a[3:2]) < nc);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    if (in_win(a, NC_A)) m_a[a[3:2]] = from_bus(d, 1'b0) & impl_of(NL_A);
    if (in_win(a, NC_B)) m_b[a[3:2]] = from_bus(d, 1'b1) & impl_of(NL_B);
  endtask

  task automatic bus_read(input logic [3:0] a, input string req);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    check(req, rd_a, in_win(a, NC_A) ? to_bus(m_a[a[3:2]], 1'b0) : 32'd0);
    check(req, rd_b, in_win(a, NC_B) ? to_bus(m_b[a[3:2]], 1'b1) : 32'd0);
  endtask

  task automatic irq_step(input logic [31:0] p, input string req);
    logic [31:0] ea, eb;
    pend_i = p;
    @(negedge clk);
    ea = '0; eb = '0;
    for (int c = 0; c < NC_A; c++) ea[c] = |(p & m_a[c]);
    for (int c = 0; c < NC_B; c++) eb[c] = |(p & m_b[c]);
    check(req, 32'(irq_a), ea);
    check(req, 32'(irq_b), eb);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] keep;
    void'($urandom(32'd1234));
    for (int c = 0; c < 4; c++) begin
      m_a[c] = impl_of(NL_A);
      m_b[c] = impl_of(NL_B);
    end
    // R1 reset state
    repeat (2) @(negedge clk);
    check("R1", 32'(irq_a), 32'd0);
    check("R1", rd_a, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 32'(irq_b), 32'd0);
    check("R1", rd_b, 32'd0);
    for (int c = 0; c < 4; c++) bus_read(4'(c * 4), "R1");
    irq_step(32'hFFFF_FFFF, "R1");

    // R5 same word in both packings: low bus byte
    bus_write(4'h0, 32'h0000_00FF);
    bus_read(4'h0, "R5");
    irq_step(32'h0100_0000, "R5");
    irq_step(32'h0000_0001, "R5");
    // R2 R3 offset 4 is core 1
    bus_write(4'h4, 32'h8000_0000);
    bus_read(4'h4, "R3");
    bus_read(4'h0, "R3");
    irq_step(32'h0000_0080, "R2");
    // R6 per-line affinity
    bus_write(4'h8, 32'h0000_0000);
    irq_step(32'h0000_0001, "R6");
    irq_step(32'h0000_0000, "R6");
    // R7 out of range and misaligned
    bus_write(4'hC, 32'h1234_5678);
    bus_write(4'h1, 32'h0);
    bus_write(4'h6, 32'h0);
    bus_read(4'hC, "R7");
    bus_read(4'h2, "R7");
    bus_read(4'h0, "R7");
    bus_read(4'h4, "R7");
    // R8 unimplemented lines
    bus_write(4'h0, 32'hFFFF_FFFF);
    bus_read(4'h0, "R8");
    irq_step(32'hFFF0_0000, "R8");
    // R9 read data holds across a write and idle cycles
    bus_read(4'h4, "R9");
    keep = rd_a;
    bus_write(4'h0, 32'h0F0F_0F0F);
    @(negedge clk);
    check("R9", rd_a, keep);

    // Random phase
    for (int i = 0; i < 400; i++) begin
      logic [3:0]  a = 4'($urandom_range(0, 15));
      logic [31:0] d = $urandom;
      case ($urandom_range(0, 2))
        0: bus_write(($urandom_range(0, 3) == 0) ? a : {a[3:2], 2'b00}, d);
        1: bus_read(($urandom_range(0, 3) == 0) ? a : {a[3:2], 2'b00}, "R4");
        default: irq_step(d & $urandom & $urandom, "R6");
      endcase
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule